// File: doc/BRIEF.md
# Dual-Reload PWM Down-Counter Timer

This block produces a pulse-width-modulated waveform from a 16-bit down-counter that, on each underflow, reloads alternately from two 16-bit period registers, A and B. When toggling is enabled the output changes level on every underflow. Register A therefore sets the length of one phase of the waveform and register B sets the other. Each reload raises a pending flag of its own, and each flag has its own interrupt enable.

A second 16-bit down-counter sits beside the first. It runs from a separate count strobe, which may be a system-timer tick or an external event. Software loads this counter, and it raises its own interrupt when it underflows.

Both counters take count strobes from an external clock selector. Counter 1 also takes a run level, which is low when the selector chooses no clock. Software reaches every register through a single-cycle write port.

Top module: `pwm_dual_timer`

## Requirements
- R1: After reset both counters are 0, `pwm_out` is 0, all three pending flags and interrupts are 0, and the next reload comes from A.
- R2: Counter 1 decrements by one on each cycle in which `c1_tick` is high, `c1_run` is high and the mode bit is set. In any other cycle it holds its value.
- R3: When counter 1 is 0 and a decrement is due, the cycle is an underflow. The counter loads the next reload value instead of 0xFFFF, taking it from A, B, A, B and so on in strict alternation.
- R4: While `c1_run` is low or the mode bit is clear, the alternation is held at A. The first reload after reset, after the mode bit is set, or after the run level returns from the stopped state therefore comes from A.
- R5: When counting is enabled, counter 1 continues from the value it already holds. It is not loaded from a reload register.
- R6: When the toggle-enable bit is set, `pwm_out` inverts on every underflow. When that bit is clear, `pwm_out` does not change on an underflow.
- R7: A control write that changes the toggle-enable bit from 0 to 1 loads the init-level bit into `pwm_out`. This takes priority over a toggle in the same cycle.
- R8: An underflow that reloads from A sets `pend[0]`. One that reloads from B sets `pend[1]`. Each `irq[i]` equals `pend[i]` AND its enable bit.
- R9: Writing 1 to a bit of the clear register clears the matching pending flag. If that flag is set in the same cycle, the set wins.
- R10: A write to counter 1 takes priority over a decrement or an underflow in the same cycle. Such a write neither sets a flag nor advances the A/B alternation.
- R11: Counter 2 is loaded by writes and decrements on each `c2_tick`; a write wins over a tick in the same cycle. A tick at 0 wraps it to 0xFFFF and sets `pend[2]`.
- R12: The `wr_sel` codes are: 0 counter 1, 1 reload A, 2 reload B, 3 counter 2, 4 control, 5 clear. The control bits are: [0] toggle enable, [1] init level, [2] irq A enable, [3] irq B enable, [4] counter 2 irq enable, [5] mode. The clear bits are: [0] A, [1] B, [2] counter 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| c1_run | input | 1 | Counter 1 clock selected (low = stopped) |
| c1_tick | input | 1 | Counter 1 count strobe |
| c2_tick | input | 1 | Counter 2 count strobe (timer tick or event) |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select |
| wr_data | input | CW (16) | Write data |
| pwm_out | output | 1 | PWM output level |
| c1_value | output | CW (16) | Counter 1 value |
| c2_value | output | CW (16) | Counter 2 value |
| pend | output | 3 | Pending flags: A reload, B reload, counter 2 underflow |
| irq | output | 3 | Interrupt lines, gated by their enables |

## Verification
The bench targets four corner cases. The first restarts the alternation after a stop: a design that keeps its A/B position across a stop would load B and shift the phase. The second puts a software write and an underflow in the same cycle: a design that lets the decrement win, or that advances the alternation anyway, would corrupt the load or swap the next two phase lengths. The third puts a flag clear and a flag set in the same cycle: a design where the clear wins would lose an interrupt. The fourth sets the toggle enable while an underflow is due: a design that toggles there instead of applying the init level would start the waveform inverted. Counter 2 is run through its wrap at zero, so an off-by-one would show up as an early or late interrupt.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
   localparam int SEL_W = 3;
   typedef enum logic [SEL_W-1:0] {
      SEL_CNT1 = 3'd0,
      SEL_RELA = 3'd1,
      SEL_RELB = 3'd2,
      SEL_CNT2 = 3'd3,
      SEL_CTRL = 3'd4,
      SEL_CLR  = 3'd5
   } pwmt_sel_e;

   localparam int CTL_TOG  = 0;
   localparam int CTL_INIT = 1;
   localparam int CTL_IEA  = 2;
   localparam int CTL_IEB  = 3;
   localparam int CTL_IET  = 4;
   localparam int CTL_MODE = 5;
   localparam int CTL_W    = 6;

   localparam int FLG_A = 0;
   localparam int FLG_B = 1;
   localparam int FLG_T = 2;
   localparam int NFLG  = 3;
endpackage

// File: rtl/pwmt_down1.sv
// Counter 1: down-counter with alternating A/B reload on underflow.
module pwmt_down1 #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          tick,
   input  logic          ld,
   input  logic [CW-1:0] ld_val,
   input  logic [CW-1:0] rel_a,
   input  logic [CW-1:0] rel_b,
   output logic [CW-1:0] count,
   output logic          uf_a,
   output logic          uf_b
);
   logic use_b;
   logic step;
   logic uf;

   assign step = en & tick & ~ld;
   assign uf   = step & (count == '0);
   assign uf_a = uf & ~use_b;
   assign uf_b = uf & use_b;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     count <= '0;
      else if (ld)    count <= ld_val;
      else if (uf)    count <= use_b ? rel_b : rel_a;
      else if (step)  count <= count - 1'b1;
   end

   // alternation is parked on A whenever counting is not enabled
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     use_b <= 1'b0;
      else if (!en)   use_b <= 1'b0;
      else if (uf)    use_b <= ~use_b;
   end
endmodule

// File: rtl/pwmt_down2.sv
// Counter 2: software-loaded down-counter that wraps at zero.
module pwmt_down2 #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          ld,
   input  logic [CW-1:0] ld_val,
   output logic [CW-1:0] count,
   output logic          uf
);
   assign uf = tick & ~ld & (count == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     count <= '0;
      else if (ld)    count <= ld_val;
      else if (tick)  count <= count - 1'b1;
   end
endmodule

// File: rtl/pwmt_flag.sv
// Pending flag: set wins over write-one clear.
module pwmt_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   input  logic ien,
   output logic pend,
   output logic irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= 1'b0;
      else        pend <= set | (pend & ~clr);
   end

   assign irq = pend & ien;
endmodule

// File: rtl/pwm_dual_timer.sv
module pwm_dual_timer
   import pwmt_pkg::*;
#(
   parameter int CW = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                c1_run,
   input  logic                c1_tick,
   input  logic                c2_tick,
   input  logic                wr_en,
   input  logic [SEL_W-1:0]    wr_sel,
   input  logic [CW-1:0]       wr_data,
   output logic                pwm_out,
   output logic [CW-1:0]       c1_value,
   output logic [CW-1:0]       c2_value,
   output logic [NFLG-1:0]     pend,
   output logic [NFLG-1:0]     irq
);
   if (CW < CTL_W) begin : g_bad_width
      $error("pwm_dual_timer: CW must hold the control field");
   end

   logic [CW-1:0]    rel_a, rel_b;
   logic [CTL_W-1:0] ctrl;
   logic             wr_c1, wr_ra, wr_rb, wr_c2, wr_ctl, wr_clr;
   logic             c1_en, uf_a, uf_b, uf_t, tog_rise;
   logic [NFLG-1:0]  set_v, clr_v, ien_v;

   assign wr_c1  = wr_en && (wr_sel == SEL_CNT1);
   assign wr_ra  = wr_en && (wr_sel == SEL_RELA);
   assign wr_rb  = wr_en && (wr_sel == SEL_RELB);
   assign wr_c2  = wr_en && (wr_sel == SEL_CNT2);
   assign wr_ctl = wr_en && (wr_sel == SEL_CTRL);
   assign wr_clr = wr_en && (wr_sel == SEL_CLR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rel_a <= '0;
         rel_b <= '0;
         ctrl  <= '0;
      end else begin
         if (wr_ra)  rel_a <= wr_data;
         if (wr_rb)  rel_b <= wr_data;
         if (wr_ctl) ctrl  <= wr_data[CTL_W-1:0];
      end
   end

   assign c1_en = c1_run & ctrl[CTL_MODE];

   pwmt_down1 #(.CW(CW)) u_c1 (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (c1_en),
      .tick   (c1_tick),
      .ld     (wr_c1),
      .ld_val (wr_data),
      .rel_a  (rel_a),
      .rel_b  (rel_b),
      .count  (c1_value),
      .uf_a   (uf_a),
      .uf_b   (uf_b)
   );

   pwmt_down2 #(.CW(CW)) u_c2 (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (c2_tick),
      .ld     (wr_c2),
      .ld_val (wr_data),
      .count  (c2_value),
      .uf     (uf_t)
   );

   assign set_v = {uf_t, uf_b, uf_a};
   assign clr_v = wr_clr ? wr_data[NFLG-1:0] : '0;
   assign ien_v = {ctrl[CTL_IET], ctrl[CTL_IEB], ctrl[CTL_IEA]};

   for (genvar g = 0; g < NFLG; g++) begin : g_flag
      pwmt_flag u_f (
         .clk   (clk),
         .rst_n (rst_n),
         .set   (set_v[g]),
         .clr   (clr_v[g]),
         .ien   (ien_v[g]),
         .pend  (pend[g]),
         .irq   (irq[g])
      );
   end

   assign tog_rise = wr_ctl & wr_data[CTL_TOG] & ~ctrl[CTL_TOG];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                pwm_out <= 1'b0;
      else if (tog_rise)                         pwm_out <= wr_data[CTL_INIT];
      else if (ctrl[CTL_TOG] && (uf_a || uf_b))  pwm_out <= ~pwm_out;
   end
endmodule

// File: rtl/pwmt_chk.sv
module pwmt_chk
   import pwmt_pkg::*;
#(
   parameter int CW = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic                c1_run,
   input logic                c1_tick,
   input logic                c2_tick,
   input logic                wr_en,
   input logic [SEL_W-1:0]    wr_sel,
   input logic [CW-1:0]       wr_data,
   input logic                pwm_out,
   input logic [CW-1:0]       c1_value,
   input logic [CW-1:0]       c2_value,
   input logic [NFLG-1:0]     pend,
   input logic [CW-1:0]       rel_a,
   input logic [CW-1:0]       rel_b,
   input logic                mode_bit,
   input logic                tog_bit
);
   logic w1, w2, wc, wk, due, under;
   assign w1    = wr_en && (wr_sel == SEL_CNT1);
   assign w2    = wr_en && (wr_sel == SEL_CNT2);
   assign wc    = wr_en && (wr_sel == SEL_CTRL);
   assign wk    = wr_en && (wr_sel == SEL_CLR);
   assign due   = c1_run && mode_bit && c1_tick && !w1;
   assign under = due && (c1_value == '0);

   assert_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (due && c1_value != '0) |=> c1_value == CW'($past(c1_value) - 1'b1));
   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!c1_tick && !w1) |=> $stable(c1_value));
   assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
      under |=> (c1_value == $past(rel_a) || c1_value == $past(rel_b)));
   assert_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (under && tog_bit && !wc) |=> pwm_out != $past(pwm_out));
   assert_still_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!tog_bit && !wc) |=> $stable(pwm_out));
   assert_init_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wc && wr_data[CTL_TOG] && !tog_bit) |=> pwm_out == $past(wr_data[CTL_INIT]));
   assert_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      under |=> (pend[FLG_A] || pend[FLG_B]));
   assert_setwins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (under && wk && wr_data[FLG_A] && wr_data[FLG_B]) |=> (pend[FLG_A] || pend[FLG_B]));
   assert_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
      w1 |=> c1_value == $past(wr_data));
   assert_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (c2_tick && !w2 && c2_value == '0) |=> (c2_value == '1 && pend[FLG_T]));
endmodule

bind pwm_dual_timer pwmt_chk #(.CW(CW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .c1_run   (c1_run),
   .c1_tick  (c1_tick),
   .c2_tick  (c2_tick),
   .wr_en    (wr_en),
   .wr_sel   (wr_sel),
   .wr_data  (wr_data),
   .pwm_out  (pwm_out),
   .c1_value (c1_value),
   .c2_value (c2_value),
   .pend     (pend),
   .rel_a    (rel_a),
   .rel_b    (rel_b),
   .mode_bit (ctrl[pwmt_pkg::CTL_MODE]),
   .tog_bit  (ctrl[pwmt_pkg::CTL_TOG])
);

// File: tb/sim_pwm_dual_timer.sv
`timescale 1ns/1ps
module sim_pwm_dual_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        c1_run = 1'b0, c1_tick = 1'b0, c2_tick = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_sel = 3'd0;
   logic [15:0] wr_data = 16'd0;
   logic        pwm_out;
   logic [15:0] c1_value, c2_value;
   logic [2:0]  pend, irq;

   int n_tests = 0, n_fail = 0;
   bit cmp_on = 1'b0;

   always #2.5 clk = ~clk;

   pwm_dual_timer u0 (
      .clk(clk), .rst_n(rst_n), .c1_run(c1_run), .c1_tick(c1_tick),
      .c2_tick(c2_tick), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .pwm_out(pwm_out), .c1_value(c1_value), .c2_value(c2_value),
      .pend(pend), .irq(irq)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   // reference model, updated on every rising edge
   logic [15:0] m_c1, m_c2, m_a, m_b;
   logic [5:0]  m_ctrl;
   bit m_nb, m_pwm, m_pa, m_pb, m_pt;
   bit e_w1, e_wa, e_wb, e_w2, e_wc, e_wk, e_en, e_uf, e_uf2;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_c1 = 0; m_c2 = 0; m_a = 0; m_b = 0; m_ctrl = 0;
         m_nb = 0; m_pwm = 0; m_pa = 0; m_pb = 0; m_pt = 0;
      end else begin
         e_w1 = wr_en && wr_sel == 0;  e_wa = wr_en && wr_sel == 1;
         e_wb = wr_en && wr_sel == 2;  e_w2 = wr_en && wr_sel == 3;
         e_wc = wr_en && wr_sel == 4;  e_wk = wr_en && wr_sel == 5;
         e_en  = c1_run && m_ctrl[5];
         e_uf  = e_en && c1_tick && !e_w1 && m_c1 == 0;
         e_uf2 = c2_tick && !e_w2 && m_c2 == 0;
         m_pa = (e_uf && !m_nb) || (m_pa && !(e_wk && wr_data[0]));
         m_pb = (e_uf && m_nb)  || (m_pb && !(e_wk && wr_data[1]));
         m_pt = e_uf2           || (m_pt && !(e_wk && wr_data[2]));
         if (e_wc && wr_data[0] && !m_ctrl[0]) m_pwm = wr_data[1];
         else if (m_ctrl[0] && e_uf)          m_pwm = !m_pwm;
         if (e_w1)                  m_c1 = wr_data;
         else if (e_uf)             m_c1 = m_nb ? m_b : m_a;
         else if (e_en && c1_tick)  m_c1 = m_c1 - 16'd1;
         if (!e_en)     m_nb = 0;
         else if (e_uf) m_nb = !m_nb;
         if (e_w2)         m_c2 = wr_data;
         else if (c2_tick) m_c2 = m_c2 - 16'd1;
         if (e_wa) m_a = wr_data;
         if (e_wb) m_b = wr_data;
         if (e_wc) m_ctrl = wr_data[5:0];
      end
   end

   always @(negedge clk) begin
      if (cmp_on) begin
         chk("R3 counter 1 value", c1_value, m_c1);
         chk("R11 counter 2 value", c2_value, m_c2);
         chk("R6 pwm level", pwm_out, m_pwm);
         chk("R8 pend A", pend[0], m_pa);
         chk("R8 pend B", pend[1], m_pb);
         chk("R11 pend counter 2", pend[2], m_pt);
         chk("R8 irq lines", irq, {m_pt & m_ctrl[4], m_pb & m_ctrl[3], m_pa & m_ctrl[2]});
      end
   end

   task automatic wr(input logic [2:0] s, input logic [15:0] d);
      wr_en = 1'b1; wr_sel = s; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 counter 1 reset", c1_value, 16'h0);
      chk("R1 counter 2 reset", c2_value, 16'h0);
      chk("R1 pwm reset", pwm_out, 1'b0);
      chk("R1 pend reset", pend, 3'b000);
      chk("R1 irq reset", irq, 3'b000);
      cmp_on = 1'b1;

      // R12 register map: reload A=3, B=5, control 0x2F
      wr(3'd1, 16'd3);
      wr(3'd2, 16'd5);
      wr(3'd0, 16'd2);
      wr(3'd4, 16'h002F);
      chk("R7 init level applied on toggle enable", pwm_out, 1'b1);
      chk("R12 counter 1 write lands", c1_value, 16'd2);
      // R5 count continues from held value
      c1_run = 1'b1; c1_tick = 1'b1;
      @(negedge clk);
      chk("R5 starts from held value", c1_value, 16'd1);
      @(negedge clk);
      @(negedge clk);
      chk("R3 first reload from A", c1_value, 16'd3);
      chk("R6 toggle on underflow", pwm_out, 1'b0);
      repeat (40) @(negedge clk);

      // mixed stimulus, model compares every cycle (R2, R4 mode entry, R6 with toggle off)
      for (int i = 0; i < 1500; i++) begin
         c1_run  = ($urandom % 16) != 0;
         c1_tick = ($urandom % 3) != 0;
         c2_tick = ($urandom % 4) == 0;
         if (($urandom % 8) == 0) begin
            wr_en = 1'b1;
            wr_sel = 3'($urandom % 6);
            wr_data = (wr_sel == 3'd4) ? 16'($urandom % 64) : 16'($urandom % 8);
         end else wr_en = 1'b0;
         @(negedge clk);
      end
      wr_en = 1'b0; c2_tick = 1'b0;

      // R4 restart from a stop reloads from A first
      wr(3'd4, 16'h002F);
      c1_run = 1'b0; c1_tick = 1'b0;
      wr(3'd1, 16'd7);
      wr(3'd2, 16'd9);
      wr(3'd0, 16'd0);
      c1_run = 1'b1; c1_tick = 1'b1;
      @(negedge clk);
      chk("R4 restart reloads A", c1_value, 16'd7);
      c1_tick = 1'b0;
      wr(3'd5, 16'd7);
      wr(3'd0, 16'd0);

      // R10 write wins over underflow, no sequence advance
      c1_tick = 1'b1;
      wr(3'd0, 16'd20);
      chk("R10 write beats underflow", c1_value, 16'd20);
      chk("R10 no flag from overridden underflow", pend[1:0], 2'b00);
      wr(3'd0, 16'd0);
      @(negedge clk);
      chk("R10 alternation kept at B", c1_value, 16'd9);
      chk("R8 B reload flag", pend[1], 1'b1);

      // R9 set wins over clear in the same cycle
      c1_tick = 1'b0;
      wr(3'd0, 16'd0);
      c1_tick = 1'b1;
      wr(3'd5, 16'd3);
      chk("R9 set beats clear", pend[0], 1'b1);
      chk("R9 clear of B", pend[1], 1'b0);
      c1_tick = 1'b0;
      wr(3'd5, 16'd1);
      chk("R9 write-one clears A", pend[0], 1'b0);

      // R7 re-enable with init level 0
      wr(3'd4, 16'h0020);
      wr(3'd4, 16'h0031);
      chk("R7 init level low", pwm_out, 1'b0);

      // R11 counter 2 wrap and interrupt
      wr(3'd3, 16'd3);
      c2_tick = 1'b1;
      repeat (3) @(negedge clk);
      chk("R11 counter 2 at zero", c2_value, 16'd0);
      chk("R11 no flag before wrap", pend[2], 1'b0);
      @(negedge clk);
      chk("R11 wrap to all ones", c2_value, 16'hFFFF);
      chk("R11 irq raised", irq[2], 1'b1);
      c2_tick = 1'b0;
      @(negedge clk);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule